// File: doc/BRIEF.md
# Multi-Mailbox Ring Pointer Manager

This block keeps the producer side of four circular mailbox areas in system memory. A device posts status indications one word at a time. The block hands back the 32-bit memory address at which each word is to be stored, and a host reads the indications back later. Each mailbox is described by a 16-bit start bound, a 16-bit exclusive bottom bound and a 16-bit tail, which is the host's read pointer. Software writes all three through a small register port. One shared register supplies the upper 16 bits of every memory address.

While posting is disabled, each mailbox's internal write pointer tracks its start bound. Once posting is enabled, each accepted post returns the current pointer joined to the shared high half. The pointer then advances by one word address and wraps back to the start when it would reach the bottom. A post is refused if it would make the pointer meet the tail, and a sticky per-mailbox overflow flag is raised instead, so unread data is never overwritten. A per-mailbox not-empty flag shows whether the write pointer differs from the tail.

Top module: `mbx_ring_mgr`

## Requirements
- R1: When the synchronous reset is applied, not_empty and overflow are all zero, post_ack is zero and the shared high-address register reads zero.
- R2: Register map, word offsets on reg_addr: start bounds at 10h+n, the shared high half at 14h, bottom bounds at 18h+n, tails at 1Ch+n, for mailbox n = 0..3. Each holds 16 bits, taken from reg_wdata[15:0]. reg_rdata[31:16] always reads zero, so bits 31..16 of a write have no effect. Any other offset reads zero.
- R3: An accepted post (post_req with post_enable high) raises post_ack in the same cycle. post_addr is then {high half, write pointer of mailbox post_mbox}, and the first post after enabling uses the start bound.
- R4: After each accepted post, the pointer of that mailbox advances by one. When the advanced value equals the bottom bound (16-bit wrap included), the pointer returns to the start bound instead.
- R5: If the advanced pointer would equal the tail, the post is refused: post_ack stays low and the pointer is unchanged. The mailbox's overflow bit is set from the next cycle and stays set while posting remains enabled.
- R6: not_empty[n] is high exactly when posting is enabled and the write pointer of mailbox n differs from its tail. A tail write takes effect in the cycle after the write.
- R7: A mailbox whose bottom bound equals its start bound is zero-size. Every post to it is refused, and its overflow bit is not set.
- R8: While post_enable is low, no post is acknowledged. From the next cycle on, every overflow bit is zero, not_empty is zero and each pointer is reloaded with its start bound.
- R9: Posts to one mailbox leave the pointer, not_empty and overflow state of every other mailbox untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| post_enable | input | 1 | Posting enabled; low reloads pointers |
| post_req | input | 1 | Request to post one word |
| post_mbox | input | 2 | Mailbox targeted by the post |
| post_ack | output | 1 | Post accepted this cycle |
| post_addr | output | 32 | Memory address for the posted word |
| not_empty | output | 4 | Per-mailbox unread-data flag |
| overflow | output | 4 | Per-mailbox sticky refused-post flag |

## Verification
The bench builds the block with its default geometry: four mailboxes, 16-bit pointers and a 5-bit register offset. This brings the full register map and the natural 16-bit pointer wrap within reach. Four-word mailboxes fill after three posts, so full refusal, sticky overflow, bottom wrap, a bound that wraps through 0000h, a zero-size mailbox and a reload after disabling are each reached within a few dozen cycles. A scoreboard queue holds the expected acknowledge and address of every post, derived from a bench-side pointer model.

// File: rtl/mbx_ring_pkg.sv
package mbx_ring_pkg;

    localparam int NUM_MBOX  = 4;
    localparam int PTR_W     = 16;
    localparam int DATA_W    = 32;
    localparam int REG_AW    = 5;
    localparam int MBOX_W    = $clog2(NUM_MBOX);
    localparam int MEM_AW    = 2 * PTR_W;

    localparam logic [REG_AW-1:0] START_BASE = 5'h10;
    localparam logic [REG_AW-1:0] HIGH_OFS   = 5'h14;
    localparam logic [REG_AW-1:0] BOTTOM_BASE = 5'h18;
    localparam logic [REG_AW-1:0] TAIL_BASE  = 5'h1C;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        ptr_t start;
        ptr_t bottom;
        ptr_t tail;
    } ring_cfg_t;

    typedef enum logic [1:0] {
        POST_IDLE   = 2'd0,
        POST_ACCEPT = 2'd1,
        POST_FULL   = 2'd2,
        POST_EMPTY_AREA = 2'd3
    } post_res_e;

    function automatic ptr_t ring_advance(ptr_t cur, ptr_t start, ptr_t bottom);
        ptr_t inc;
        inc = ptr_t'(cur + 1'b1);
        return (inc == bottom) ? start : inc;
    endfunction

    function automatic logic [REG_AW-1:0] mbox_ofs(logic [REG_AW-1:0] base, int idx);
        return base + REG_AW'(idx);
    endfunction

endpackage

// File: rtl/mbx_ring_regs.sv
module mbx_ring_regs
    import mbx_ring_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output ring_cfg_t [NUM_MBOX-1:0] cfg,
    output ptr_t                  high_half
);

    localparam int PAD_W = DATA_W - PTR_W;

    ptr_t wr_val;
    logic unused_wdata_hi;

    assign wr_val          = reg_wdata[PTR_W-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:PTR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            high_half <= '0;
        end else if (reg_wr && reg_addr == HIGH_OFS) begin
            high_half <= wr_val;
        end
    end

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_bounds
        // Bounds and tails carry no reset value; software programs them.
        always_ff @(posedge clk) begin
            if (reg_wr && reg_addr == mbox_ofs(START_BASE, g)) begin
                cfg[g].start <= wr_val;
            end
            if (reg_wr && reg_addr == mbox_ofs(BOTTOM_BASE, g)) begin
                cfg[g].bottom <= wr_val;
            end
            if (reg_wr && reg_addr == mbox_ofs(TAIL_BASE, g)) begin
                cfg[g].tail <= wr_val;
            end
        end
    end

    always_comb begin
        ptr_t sel;
        sel = '0;
        if (reg_addr == HIGH_OFS) begin
            sel = high_half;
        end
        for (int i = 0; i < NUM_MBOX; i++) begin
            if (reg_addr == mbox_ofs(START_BASE, i))  sel = cfg[i].start;
            if (reg_addr == mbox_ofs(BOTTOM_BASE, i)) sel = cfg[i].bottom;
            if (reg_addr == mbox_ofs(TAIL_BASE, i))   sel = cfg[i].tail;
        end
        reg_rdata = {{PAD_W{1'b0}}, sel};
    end

endmodule

// File: rtl/mbx_ring_chan.sv
module mbx_ring_chan
    import mbx_ring_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      sel,
    input  ring_cfg_t cfg,
    output post_res_e result,
    output ptr_t      wptr,
    output logic      not_empty,
    output logic      overflow
);

    ptr_t nxt;
    logic zero_area;
    logic would_fill;

    assign nxt        = ring_advance(wptr, cfg.start, cfg.bottom);
    assign zero_area  = (cfg.start == cfg.bottom);
    assign would_fill = (nxt == cfg.tail);

    always_comb begin
        if (!(enable && sel))  result = POST_IDLE;
        else if (zero_area)    result = POST_EMPTY_AREA;
        else if (would_fill)   result = POST_FULL;
        else                   result = POST_ACCEPT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            overflow <= 1'b0;
        end else if (!enable) begin
            wptr     <= cfg.start;
            overflow <= 1'b0;
        end else begin
            if (result == POST_ACCEPT) begin
                wptr <= nxt;
            end
            if (result == POST_FULL) begin
                overflow <= 1'b1;
            end
        end
    end

    assign not_empty = enable && (wptr != cfg.tail);

endmodule

// File: rtl/mbx_ring_post_mux.sv
module mbx_ring_post_mux
    import mbx_ring_pkg::*;
(
    input  logic                  post_req,
    input  logic [MBOX_W-1:0]     post_mbox,
    input  post_res_e [NUM_MBOX-1:0] results,
    input  ptr_t [NUM_MBOX-1:0]   wptrs,
    input  ptr_t                  high_half,
    output logic [NUM_MBOX-1:0]   sel,
    output logic                  post_ack,
    output logic [MEM_AW-1:0]     post_addr
);

    logic [NUM_MBOX-1:0] acc;

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_sel
        assign sel[g] = post_req && (post_mbox == MBOX_W'(g));
        assign acc[g] = (results[g] == POST_ACCEPT);
    end

    assign post_ack  = |acc;
    assign post_addr = {high_half, wptrs[post_mbox]};

endmodule

// File: rtl/mbx_ring_mgr.sv
module mbx_ring_mgr
    import mbx_ring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 post_enable,
    input  logic                 post_req,
    input  logic [MBOX_W-1:0]    post_mbox,
    output logic                 post_ack,
    output logic [MEM_AW-1:0]    post_addr,
    output logic [NUM_MBOX-1:0]  not_empty,
    output logic [NUM_MBOX-1:0]  overflow
);

    ring_cfg_t [NUM_MBOX-1:0] cfg;
    ptr_t                     high_half;
    post_res_e [NUM_MBOX-1:0] results;
    ptr_t [NUM_MBOX-1:0]      wptrs;
    logic [NUM_MBOX-1:0]      sel;

    mbx_ring_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg),
        .high_half (high_half)
    );

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_chan
        mbx_ring_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .enable    (post_enable),
            .sel       (sel[g]),
            .cfg       (cfg[g]),
            .result    (results[g]),
            .wptr      (wptrs[g]),
            .not_empty (not_empty[g]),
            .overflow  (overflow[g])
        );
    end

    mbx_ring_post_mux u_mux (
        .post_req  (post_req),
        .post_mbox (post_mbox),
        .results   (results),
        .wptrs     (wptrs),
        .high_half (high_half),
        .sel       (sel),
        .post_ack  (post_ack),
        .post_addr (post_addr)
    );

endmodule

// File: rtl/mbx_ring_mgr_chk.sv
module mbx_ring_mgr_chk
    import mbx_ring_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [REG_AW-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                post_enable,
    input logic                post_req,
    input logic [MBOX_W-1:0]   post_mbox,
    input logic                post_ack,
    input logic [NUM_MBOX-1:0] not_empty,
    input logic [NUM_MBOX-1:0] overflow
);

    assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        post_ack |-> (post_req && post_enable));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:PTR_W] == '0);

    assert_disabled_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !post_enable |=> (overflow == '0));

    assert_disabled_empty_R6: assert property (@(posedge clk) disable iff (rst)
        !post_enable |-> (not_empty == '0));

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_mb
        assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
            (post_enable && overflow[g]) |=> (!post_enable || overflow[g]));

        assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(overflow[g]) |-> $past(post_req && post_mbox == MBOX_W'(g) && !post_ack));
    end

endmodule

bind mbx_ring_mgr mbx_ring_mgr_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .post_enable (post_enable),
    .post_req    (post_req),
    .post_mbox   (post_mbox),
    .post_ack    (post_ack),
    .not_empty   (not_empty),
    .overflow    (overflow)
);

// File: tb/mbx_ring_mgr_tb_top.sv
`timescale 1ns/1ps
module mbx_ring_mgr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        post_enable = 1'b0;
    logic        post_req = 1'b0;
    logic [1:0]  post_mbox = '0;
    logic        post_ack;
    logic [31:0] post_addr;
    logic [3:0]  not_empty;
    logic [3:0]  overflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mbx_ring_mgr dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .post_enable(post_enable),
        .post_req(post_req), .post_mbox(post_mbox), .post_ack(post_ack),
        .post_addr(post_addr), .not_empty(not_empty), .overflow(overflow)
    );

    typedef struct {
        logic        ack;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Bench-side model
    logic [15:0] m_start[4], m_bot[4], m_tail[4], m_wp[4];
    logic [15:0] m_high;
    logic [3:0]  m_ovf;
    logic        m_en;

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: pops the expected outcome for every request
    always @(negedge clk) begin
        if (post_req) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected request", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " ack"}, {31'd0, post_ack}, {31'd0, e.ack});
                if (e.ack) check({e.tag, " addr"}, post_addr, e.addr);
            end
        end
    end

    task automatic reg_write(logic [4:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (a == 5'h10 + 5'(i)) m_start[i] = d[15:0];
            if (a == 5'h18 + 5'(i)) m_bot[i]   = d[15:0];
            if (a == 5'h1C + 5'(i)) m_tail[i]  = d[15:0];
        end
        if (a == 5'h14) m_high = d[15:0];
        if (!m_en) for (int i = 0; i < 4; i++) m_wp[i] = m_start[i];
    endtask

    task automatic reg_read(string tag, logic [4:0] a, logic [31:0] expv);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        check(tag, reg_rdata, expv);
    endtask

    task automatic set_enable(logic v);
        @(posedge clk); #1;
        post_enable = v;
        @(posedge clk); #1;
        m_en = v;
        if (!v) begin
            m_ovf = '0;
            for (int i = 0; i < 4; i++) m_wp[i] = m_start[i];
        end
    endtask

    task automatic post(int mb, string tag);
        exp_t e;
        logic [15:0] inc, nxt;
        logic zero, full;
        inc  = m_wp[mb] + 16'd1;
        nxt  = (inc == m_bot[mb]) ? m_start[mb] : inc;
        zero = (m_start[mb] == m_bot[mb]);
        full = (nxt == m_tail[mb]);
        e.ack  = m_en && !zero && !full;
        e.addr = {m_high, m_wp[mb]};
        e.tag  = tag;
        @(posedge clk); #1;
        exp_q.push_back(e);
        post_req = 1'b1; post_mbox = 2'(mb);
        @(posedge clk); #1;
        post_req = 1'b0;
        if (e.ack) m_wp[mb] = nxt;
        if (m_en && !zero && full) m_ovf[mb] = 1'b1;
    endtask

    task automatic check_flags(string tag);
        logic [3:0] ne;
        @(negedge clk);
        for (int i = 0; i < 4; i++) ne[i] = m_en && (m_wp[i] != m_tail[i]);
        check({tag, " not_empty"}, {28'd0, not_empty}, {28'd0, ne});
        check({tag, " overflow"},  {28'd0, overflow},  {28'd0, m_ovf});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_high = '0; m_ovf = '0; m_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_start[i] = '0; m_bot[i] = '0; m_tail[i] = '0; m_wp[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 not_empty", {28'd0, not_empty}, 32'd0);
        check("R1 overflow",  {28'd0, overflow},  32'd0);
        check("R1 post_ack",  {31'd0, post_ack},  32'd0);
        reg_read("R1 high reset", 5'h14, 32'd0);

        // R2 programming and readback
        reg_write(5'h14, 32'hFFFF_8765);
        reg_write(5'h10, 32'h0000_0100); reg_write(5'h18, 32'h0000_0104); reg_write(5'h1C, 32'h0000_0100);
        reg_write(5'h11, 32'h0000_0200); reg_write(5'h19, 32'h0000_0200); reg_write(5'h1D, 32'h0000_0200);
        reg_write(5'h12, 32'h0000_FFFC); reg_write(5'h1A, 32'h0000_0000); reg_write(5'h1E, 32'h0000_FFFC);
        reg_write(5'h13, 32'h0000_0300); reg_write(5'h1B, 32'hABCD_0310); reg_write(5'h1F, 32'h5555_0300);
        reg_read("R2 high half", 5'h14, 32'h0000_8765);
        reg_read("R2 bottom3 upper ignored", 5'h1B, 32'h0000_0310);
        reg_read("R2 tail3 upper ignored", 5'h1F, 32'h0000_0300);
        reg_read("R2 start2", 5'h12, 32'h0000_FFFC);
        reg_read("R2 bottom0", 5'h18, 32'h0000_0104);
        reg_read("R2 unmapped", 5'h05, 32'h0000_0000);

        set_enable(1'b1);
        check_flags("R6 enabled idle");

        // R3/R4 fill mailbox 0 then R5 refusal
        post(0, "R3 first post mb0");
        post(0, "R4 advance mb0");
        post(0, "R4 advance mb0 third");
        check_flags("R6 mb0 holds data");
        post(0, "R5 full mb0 refused");
        check_flags("R5 overflow mb0");
        post(0, "R5 still full mb0");

        // R6 tail write frees space
        reg_write(5'h1C, 32'h0000_0102);
        check_flags("R6 after tail write");
        post(0, "R4 last slot mb0");
        post(0, "R4 wrap to start mb0");
        post(0, "R5 full after wrap mb0");
        reg_write(5'h1C, 32'h0000_0101);
        check_flags("R6 tail reaches wptr");

        // R7 zero-size mailbox
        post(1, "R7 zero-size mb1");
        check_flags("R7 no overflow mb1");

        // R4 wrap across 16-bit boundary, R9 independence
        post(2, "R4 mb2 first");
        post(2, "R4 mb2 second");
        post(2, "R4 mb2 third");
        post(2, "R5 mb2 full");
        reg_write(5'h1E, 32'h0000_FFFE);
        post(2, "R4 mb2 last before bottom");
        post(2, "R4 mb2 wrapped");
        check_flags("R9 independent flags");

        // R8 disable clears and reloads
        set_enable(1'b0);
        check_flags("R8 disabled");
        post(0, "R8 no ack while disabled");
        reg_write(5'h1C, 32'h0000_0103);
        set_enable(1'b1);
        post(0, "R8 reload to start mb0");
        check_flags("R8 re-enabled");

        repeat (3) @(posedge clk);
        check("R3 scoreboard drained", exp_q.size(), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule